// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter with Alarm

This block keeps wall-clock time and date as packed BCD bytes. A fast strobe (`sub_tick`) is divided by a parameter to give one advance per second. Each advance moves a carry chain through seconds, minutes, hours, day of week, day of month, month and a two-digit year. The date chain knows 30-day months, 31-day months and February in leap years. Hours run in 24-hour form or in 12-hour form with a PM flag. The mode is chosen by bit 7 of the stored hours byte.

Software loads any counter through a write port and reads any register through a combinational read port. A register index selects the register: indices 0 to 6 are the time and date counters and indices 8 to 10 are the alarm seconds, minutes and hours. Three alarm registers are compared with the time after each advance. When they match, the block raises a one-cycle `alarm_hit` pulse. A run control freezes counting and clears the sub-second phase.

Top module: `rtc_calendar`

## Requirements
- R1: After reset the time reads 00:00:00 in 24-hour form, day of week 01, date 01, month 01, year 00, all alarm registers 00, and `alarm_hit` is 0.
- R2: While `run` is high, every SUB_DIV-th `sub_tick` strobe advances seconds by one in BCD. Seconds 59 wrap to 00 and carry into minutes. Without a strobe or a write, seconds hold.
- R3: Minutes 59 wrap to 00 and carry into hours. Minutes 00 to 58 advance by one in BCD.
- R4: In 24-hour form (hours bit 7 = 0, value 00 to 23), hours 23 wrap to 00 and carry one day.
- R5: In 12-hour form, hours bit 7 = 1, bit 6 = 0, bit 5 = PM, and bits 4:0 hold 01 to 12 in BCD. 11 goes to 12 and flips PM, and 12 goes to 01 with PM kept. Only PM 11 going to AM 12 carries one day.
- R6: A day carry advances day of week (07 wraps to 01) and the date. The date wraps to 01 and carries the month after 30 in months 04, 06, 09 and 11, and after 31 in all other months except 02.
- R7: February ends after 28, or after 29 when the year is divisible by 4 (00, 04, …, 96; 00 counts as a leap year).
- R8: Month 12 wraps to 01 and carries the year. Year 99 wraps to 00.
- R9: While `run` is low, no advance occurs and the sub-second phase is held at zero. After `run` rises, a full SUB_DIV strobes are needed for the next advance.
- R10: A write loads `wr_data` unchanged into register `wr_idx` (0 sec, 1 min, 2 hour, 3 day of week, 4 date, 5 month, 6 year, 8 alarm sec, 9 alarm min, 10 alarm hour) on the next edge. Writing seconds also restarts the sub-second phase.
- R11: `rd_data` shows the register at `rd_idx` combinationally. Indices 7 and 11 to 15 read 00.
- R12: `alarm_hit` pulses for exactly one cycle, in the cycle the new second first appears, when seconds, minutes and hours bits 5:0 equal the alarm registers. Alarm hours bits 7 and 6 are ignored, and bit 5 (PM or tens) takes part in the match.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Counting enable; low stops time and clears the sub-second phase |
| sub_tick | input | 1 | Single-cycle strobe, SUB_DIV per second |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 4 | Register index for a write |
| wr_data | input | 8 | BCD value to load |
| rd_idx | input | 4 | Register index for a read |
| rd_data | output | 8 | Register contents at `rd_idx` |
| alarm_hit | output | 1 | One-cycle pulse when a new second matches the alarm |

## Verification
The range assertions on seconds, hours, day of week and month assume every write carries a legal BCD value for its register, with bit 6 clear in 12-hour hours. The bench only loads such values. The gating and pulse assertions assume `sub_tick` is a single-cycle strobe and that `run` changes are ordinary level changes. The bench drives each strobe for one cycle, with an idle cycle between strobes, and never writes in the same cycle as a strobe.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

    localparam int IDX_W     = 4;
    localparam logic [IDX_W-1:0] IDX_SEC   = 4'd0;
    localparam logic [IDX_W-1:0] IDX_MIN   = 4'd1;
    localparam logic [IDX_W-1:0] IDX_HOUR  = 4'd2;
    localparam logic [IDX_W-1:0] IDX_DOW   = 4'd3;
    localparam logic [IDX_W-1:0] IDX_DATE  = 4'd4;
    localparam logic [IDX_W-1:0] IDX_MONTH = 4'd5;
    localparam logic [IDX_W-1:0] IDX_YEAR  = 4'd6;
    localparam logic [IDX_W-1:0] IDX_ASEC  = 4'd8;
    localparam logic [IDX_W-1:0] IDX_AMIN  = 4'd9;
    localparam logic [IDX_W-1:0] IDX_AHOUR = 4'd10;

    typedef logic [7:0] bcd8_t;

    typedef struct packed {
        bcd8_t sec;
        bcd8_t min;
        bcd8_t hour;
        bcd8_t dow;
        bcd8_t date;
        bcd8_t month;
        bcd8_t year;
    } cal_t;

    typedef struct packed {
        bcd8_t sec;
        bcd8_t min;
        bcd8_t hour;
    } alarm_t;

    typedef struct packed {
        bcd8_t val;
        logic  carry;
    } step_t;

    localparam cal_t CAL_RESET = '{sec: 8'h00, min: 8'h00, hour: 8'h00, dow: 8'h01,
                                   date: 8'h01, month: 8'h01, year: 8'h00};

    function automatic bcd8_t bcd_inc(input bcd8_t v);
        if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
        return v + 8'd1;
    endfunction

    function automatic step_t bcd_wrap(input bcd8_t v, input bcd8_t last, input bcd8_t first);
        step_t r;
        r.carry = (v == last);
        r.val   = r.carry ? first : bcd_inc(v);
        return r;
    endfunction

    // year argument is the low five bits: tens parity plus the units digit
    function automatic logic is_leap(input logic [4:0] y);
        if (y[4]) return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
        return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
    endfunction

    function automatic bcd8_t month_last(input bcd8_t m, input logic leap);
        case (m)
            8'h02:                      return leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

    function automatic step_t hour_step(input logic mode12, input logic pm, input logic [5:0] v);
        step_t r;
        if (mode12) begin
            if (v[4:0] == 5'h11) begin
                r.val   = {2'b10, ~pm, 5'h12};
                r.carry = pm;
            end else if (v[4:0] == 5'h12) begin
                r.val   = {2'b10, pm, 5'h01};
                r.carry = 1'b0;
            end else begin
                r.val   = bcd_inc({3'b000, v[4:0]}) | {2'b10, pm, 5'b0};
                r.carry = 1'b0;
            end
        end else begin
            r.carry = (v == 6'h23);
            r.val   = r.carry ? 8'h00 : bcd_inc({2'b00, v});
        end
        return r;
    endfunction

endpackage

// File: rtl/rtc_subsec_div.sv
module rtc_subsec_div
    import rtc_cal_pkg::*;
#(
    parameter int SUB_DIV = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             sub_tick,
    input  logic             clr,
    output logic             adv
);
    localparam int CNT_W = (SUB_DIV > 1) ? $clog2(SUB_DIV) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SUB_DIV - 1);

    logic [CNT_W-1:0] cnt_q;

    assign adv = run && sub_tick && (cnt_q == CNT_LAST);

    always_ff @(posedge clk) begin
        if (rst || !run || clr) begin
            cnt_q <= '0;
        end else if (sub_tick) begin
            cnt_q <= adv ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/rtc_time_chain.sv
module rtc_time_chain
    import rtc_cal_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  bcd8_t            wr_data,
    output cal_t             now_q,
    output bcd8_t            nxt_sec,
    output bcd8_t            nxt_min,
    output logic [5:0]       nxt_hr
);
    cal_t  now_d;
    step_t s_st, m_st, h_st, w_st, d_st, mo_st, y_st;
    bcd8_t last_day;

    always_comb begin
        last_day = month_last(now_q.month, is_leap(now_q.year[4:0]));
        s_st  = bcd_wrap(now_q.sec, 8'h59, 8'h00);
        m_st  = bcd_wrap(now_q.min, 8'h59, 8'h00);
        h_st  = hour_step(now_q.hour[7], now_q.hour[5], now_q.hour[5:0]);
        w_st  = bcd_wrap(now_q.dow, 8'h07, 8'h01);
        d_st  = bcd_wrap(now_q.date, last_day, 8'h01);
        mo_st = bcd_wrap(now_q.month, 8'h12, 8'h01);
        y_st  = bcd_wrap(now_q.year, 8'h99, 8'h00);

        now_d = now_q;
        if (adv) begin
            now_d.sec = s_st.val;
            if (s_st.carry) begin
                now_d.min = m_st.val;
                if (m_st.carry) begin
                    now_d.hour = h_st.val;
                    if (h_st.carry) begin
                        now_d.dow  = w_st.val;
                        now_d.date = d_st.val;
                        if (d_st.carry) begin
                            now_d.month = mo_st.val;
                            if (mo_st.carry) now_d.year = y_st.val;
                        end
                    end
                end
            end
        end

        if (wr_en) begin
            case (wr_idx)
                IDX_SEC:   now_d.sec   = wr_data;
                IDX_MIN:   now_d.min   = wr_data;
                IDX_HOUR:  now_d.hour  = wr_data;
                IDX_DOW:   now_d.dow   = wr_data;
                IDX_DATE:  now_d.date  = wr_data;
                IDX_MONTH: now_d.month = wr_data;
                IDX_YEAR:  now_d.year  = wr_data;
                default:   ;
            endcase
        end
    end

    assign nxt_sec = now_d.sec;
    assign nxt_min = now_d.min;
    assign nxt_hr  = now_d.hour[5:0];

    always_ff @(posedge clk) begin
        if (rst) now_q <= CAL_RESET;
        else     now_q <= now_d;
    end
endmodule

// File: rtl/rtc_alarm_unit.sv
module rtc_alarm_unit
    import rtc_cal_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  bcd8_t            wr_data,
    input  bcd8_t            nxt_sec,
    input  bcd8_t            nxt_min,
    input  logic [5:0]       nxt_hr,
    output alarm_t           alm_q,
    output logic             hit
);
    logic match;

    assign match = (nxt_sec == alm_q.sec) && (nxt_min == alm_q.min)
                && (nxt_hr == alm_q.hour[5:0]);

    always_ff @(posedge clk) begin
        if (rst) begin
            alm_q <= '0;
            hit   <= 1'b0;
        end else begin
            if (wr_en) begin
                case (wr_idx)
                    IDX_ASEC:  alm_q.sec  <= wr_data;
                    IDX_AMIN:  alm_q.min  <= wr_data;
                    IDX_AHOUR: alm_q.hour <= wr_data;
                    default:   ;
                endcase
            end
            hit <= adv && match;
        end
    end
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
    import rtc_cal_pkg::*;
#(
    parameter int SUB_DIV = 32
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic       sub_tick,
    input  logic       wr_en,
    input  logic [3:0] wr_idx,
    input  logic [7:0] wr_data,
    input  logic [3:0] rd_idx,
    output logic [7:0] rd_data,
    output logic       alarm_hit
);
    logic       sec_adv;
    cal_t       now_q;
    alarm_t     alm_q;
    bcd8_t      nxt_sec, nxt_min;
    logic [5:0] nxt_hr;

    rtc_subsec_div #(.SUB_DIV(SUB_DIV)) u_div (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .sub_tick (sub_tick),
        .clr      (wr_en && (wr_idx == IDX_SEC)),
        .adv      (sec_adv)
    );

    rtc_time_chain u_chain (
        .clk     (clk),
        .rst     (rst),
        .adv     (sec_adv),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .now_q   (now_q),
        .nxt_sec (nxt_sec),
        .nxt_min (nxt_min),
        .nxt_hr  (nxt_hr)
    );

    rtc_alarm_unit u_alarm (
        .clk     (clk),
        .rst     (rst),
        .adv     (sec_adv),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .nxt_sec (nxt_sec),
        .nxt_min (nxt_min),
        .nxt_hr  (nxt_hr),
        .alm_q   (alm_q),
        .hit     (alarm_hit)
    );

    always_comb begin
        case (rd_idx)
            IDX_SEC:   rd_data = now_q.sec;
            IDX_MIN:   rd_data = now_q.min;
            IDX_HOUR:  rd_data = now_q.hour;
            IDX_DOW:   rd_data = now_q.dow;
            IDX_DATE:  rd_data = now_q.date;
            IDX_MONTH: rd_data = now_q.month;
            IDX_YEAR:  rd_data = now_q.year;
            IDX_ASEC:  rd_data = alm_q.sec;
            IDX_AMIN:  rd_data = alm_q.min;
            IDX_AHOUR: rd_data = alm_q.hour;
            default:   rd_data = 8'h00;
        endcase
    end
endmodule

// File: rtl/rtc_calendar_chk.sv
module rtc_calendar_chk (
    input logic       clk,
    input logic       rst,
    input logic       run,
    input logic       adv,
    input logic       wr_en,
    input logic       alarm_hit,
    input logic [7:0] sec,
    input logic [7:0] hour,
    input logic [7:0] dow,
    input logic [7:0] month
);
    // R9
    run_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !run |-> !adv);

    // R12
    hit_after_adv_chk: assert property (@(posedge clk) disable iff (rst)
        alarm_hit |-> $past(adv));

    // R2
    sec_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!adv && !wr_en) |=> $stable(sec));

    // R2
    sec_range_chk: assert property (@(posedge clk) disable iff (rst)
        (sec[3:0] <= 4'd9) && (sec <= 8'h59));

    // R4
    hour24_range_chk: assert property (@(posedge clk) disable iff (rst)
        !hour[7] |-> (hour <= 8'h23) && (hour[3:0] <= 4'd9));

    // R5
    hour12_range_chk: assert property (@(posedge clk) disable iff (rst)
        hour[7] |-> !hour[6] && (hour[4:0] >= 5'h01) && (hour[4:0] <= 5'h12)
                    && (hour[3:0] <= 4'd9));

    // R6
    dow_range_chk: assert property (@(posedge clk) disable iff (rst)
        (dow >= 8'h01) && (dow <= 8'h07));

    // R8
    month_range_chk: assert property (@(posedge clk) disable iff (rst)
        (month >= 8'h01) && (month <= 8'h12) && (month[3:0] <= 4'd9));
endmodule

bind rtc_calendar rtc_calendar_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .run       (run),
    .adv       (sec_adv),
    .wr_en     (wr_en),
    .alarm_hit (alarm_hit),
    .sec       (now_q.sec),
    .hour      (now_q.hour),
    .dow       (now_q.dow),
    .month     (now_q.month)
);

// File: tb/rtc_calendar_test.sv
module rtc_calendar_test;
    localparam int CLK_PERIOD = 10;
    localparam int SUB_DIV    = 4;
    localparam int NVEC       = 19;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       run = 1'b1;
    logic       sub_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_idx = '0;
    logic [7:0] wr_data = '0;
    logic [3:0] rd_idx = '0;
    logic [7:0] rd_data;
    logic       alarm_hit;

    int checks = 0;
    int errors = 0;
    int hits   = 0;
    bit done   = 1'b0;

    rtc_calendar #(.SUB_DIV(SUB_DIV)) uut (
        .clk(clk), .rst(rst), .run(run), .sub_tick(sub_tick),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .rd_idx(rd_idx), .rd_data(rd_data), .alarm_hit(alarm_hit)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // each vector: {start, expected one second later}; byte order sec,min,hour,dow,date,month,year
    localparam logic [111:0] VEC [NVEC] = '{
        {56'h56_34_12_03_15_06_25, 56'h57_34_12_03_15_06_25}, // R2 plain second
        {56'h59_34_12_03_15_06_25, 56'h00_35_12_03_15_06_25}, // R2 seconds wrap
        {56'h59_59_12_03_15_06_25, 56'h00_00_13_03_15_06_25}, // R3 minutes wrap
        {56'h59_59_23_07_15_06_25, 56'h00_00_00_01_16_06_25}, // R4 day carry, dow wrap
        {56'h59_59_23_02_30_04_25, 56'h00_00_00_03_01_05_25}, // R6 30-day month
        {56'h59_59_23_02_30_05_25, 56'h00_00_00_03_31_05_25}, // R6 31-day month
        {56'h59_59_23_02_28_02_25, 56'h00_00_00_03_01_03_25}, // R7 common February
        {56'h59_59_23_02_28_02_24, 56'h00_00_00_03_29_02_24}, // R7 leap February
        {56'h59_59_23_02_29_02_24, 56'h00_00_00_03_01_03_24}, // R7 leap day end
        {56'h59_59_23_02_28_02_00, 56'h00_00_00_03_29_02_00}, // R7 year 00 leap
        {56'h59_59_23_02_28_02_10, 56'h00_00_00_03_01_03_10}, // R7 year 10 common
        {56'h59_59_23_02_28_02_12, 56'h00_00_00_03_29_02_12}, // R7 year 12 leap
        {56'h59_59_23_05_31_12_25, 56'h00_00_00_06_01_01_26}, // R8 year carry
        {56'h59_59_23_05_31_12_99, 56'h00_00_00_06_01_01_00}, // R8 year wrap
        {56'h59_59_91_03_15_06_25, 56'h00_00_B2_03_15_06_25}, // R5 AM 11 -> PM 12
        {56'h59_59_B2_03_15_06_25, 56'h00_00_A1_03_15_06_25}, // R5 PM 12 -> PM 01
        {56'h59_59_B1_03_15_06_25, 56'h00_00_92_04_16_06_25}, // R5 PM 11 -> AM 12, day
        {56'h59_59_89_03_15_06_25, 56'h00_00_90_03_15_06_25}, // R5 09 -> 10
        {56'h59_59_92_03_15_06_25, 56'h00_00_81_03_15_06_25}  // R5 AM 12 -> AM 01
    };
    localparam string VTAG [NVEC] = '{
        "R2", "R2", "R3", "R4", "R6", "R6", "R7", "R7", "R7", "R7",
        "R7", "R7", "R8", "R8", "R5", "R5", "R5", "R5", "R5"
    };

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic check8(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic check_int(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] idx, input logic [7:0] val);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = idx; wr_data = val;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] idx, output logic [7:0] val);
        rd_idx = idx;
        #1;
        val = rd_data;
    endtask

    task automatic load_cal(input logic [55:0] c);
        for (int i = 0; i < 7; i++) wr(4'(i), c[55-8*i -: 8]);
    endtask

    task automatic read_cal(output logic [55:0] c);
        logic [7:0] v;
        for (int i = 0; i < 7; i++) begin
            rd(4'(i), v);
            c[55-8*i -: 8] = v;
        end
    endtask

    task automatic strobes(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            hits += int'(alarm_hit);
            sub_tick = 1'b1;
            @(negedge clk);
            hits += int'(alarm_hit);
            sub_tick = 1'b0;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        logic [55:0] got;
        logic [7:0]  v;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        read_cal(got);
        checks++;
        if (got !== 56'h00_00_00_01_01_01_00) begin
            errors++;
            $display("FAIL R1 reset time: got %h expected %h", got, 56'h00_00_00_01_01_01_00);
        end
        for (int i = 8; i <= 10; i++) begin
            rd(4'(i), v);
            check8("R1 alarm reg reset", v, 8'h00);
        end
        check8("R1 alarm_hit reset", {7'b0, alarm_hit}, 8'h00);

        // R11 unused indices
        rd(4'd7, v);  check8("R11 idx 7", v, 8'h00);
        rd(4'd11, v); check8("R11 idx 11", v, 8'h00);
        rd(4'd15, v); check8("R11 idx 15", v, 8'h00);

        // vector table: load, one second, compare
        for (int k = 0; k < NVEC; k++) begin
            load_cal(VEC[k][111:56]);
            strobes(SUB_DIV);
            read_cal(got);
            checks++;
            if (got !== VEC[k][55:0]) begin
                errors++;
                $display("FAIL %s vector %0d: got %h expected %h", VTAG[k], k, got, VEC[k][55:0]);
            end
        end

        // R9 run low stops counting and clears phase
        load_cal(56'h10_00_00_01_01_01_00);
        strobes(2);
        rd(4'd0, v); check8("R2 partial phase no advance", v, 8'h10);
        run = 1'b0;
        strobes(6);
        rd(4'd0, v); check8("R9 stopped", v, 8'h10);
        run = 1'b1;
        strobes(SUB_DIV - 1);
        rd(4'd0, v); check8("R9 phase cleared by stop", v, 8'h10);
        strobes(1);
        rd(4'd0, v); check8("R9 resume after full period", v, 8'h11);

        // R10 seconds write restarts the phase
        strobes(SUB_DIV - 1);
        wr(4'd0, 8'h20);
        strobes(SUB_DIV - 1);
        rd(4'd0, v); check8("R10 phase restart", v, 8'h20);
        strobes(1);
        rd(4'd0, v); check8("R10 advance after write", v, 8'h21);

        // R12 alarm, hour bits 7:6 ignored
        load_cal(56'h03_30_12_01_01_01_00);
        wr(4'd8, 8'h05);
        wr(4'd9, 8'h30);
        wr(4'd10, 8'hD2);
        rd(4'd10, v); check8("R10 alarm hour readback", v, 8'hD2);
        hits = 0;
        strobes(SUB_DIV);
        check_int("R12 no hit before match", hits, 0);
        strobes(SUB_DIV);
        rd(4'd0, v); check8("R12 second at match", v, 8'h05);
        check_int("R12 hit on match", hits, 1);
        strobes(SUB_DIV);
        check_int("R12 single pulse", hits, 1);

        // R12 12-hour PM match uses bit 5
        load_cal(56'h09_15_B2_01_01_01_00);
        wr(4'd8, 8'h10);
        wr(4'd9, 8'h15);
        wr(4'd10, 8'h32);
        hits = 0;
        strobes(SUB_DIV);
        check_int("R12 PM hour match", hits, 1);
        load_cal(56'h09_15_92_01_01_01_00);
        hits = 0;
        strobes(SUB_DIV);
        check_int("R12 AM hour no match", hits, 0);

        done = 1'b1;
        finish_run();
    end
endmodule